// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked on-chip requester and an external static RAM that has no clock of its own: 128K words of 16 bits, with active-low chip, output and write enables and active-low selects for the upper and lower bytes. Each request is a single word access. It carries a read/write flag, a 17-bit word address, a two-bit byte-enable mask and the write data. The controller turns the request into a pin sequence that lasts long enough for the memory's access time. When a read finishes, it returns the word with a one-cycle valid pulse.

The length of an access is fixed when the block is built. It comes from the memory access time and the controller clock period, both given in picoseconds. Supported access times run from 8 to 35 ns, and an access is never shorter than one cycle. The data bus is bidirectional. It is split into an outgoing path, an incoming path and a drive-enable, so the pad cell that joins them stays outside the block. A one-cycle interval follows each write, in which the controller has stopped driving and the chip is still selected. This keeps the controller and the memory from driving the bus at the same time. A request whose byte mask is all zero touches no pin.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the chip, output and write enables and both byte selects are high (inactive), the data bus is not driven, and `busy` and `rspValid` are low. While chip enable is high, every other memory control is high and the bus is not driven.
- R2: A read with a non-zero mask holds chip enable and output enable low and write enable high for exactly WAIT_CYC cycles, starting in the cycle after acceptance. During those cycles the address pins carry the request address. The address and byte selects stay stable for as long as chip enable is low.
- R3: A write with a non-zero mask holds chip enable and write enable low and output enable high for exactly WAIT_CYC cycles. The data bus is driven with the request data in exactly those cycles and in no others.
- R4: Byte-enable bit 0 selects data bits 7:0 and pulls the lower-byte select low. Byte-enable bit 1 selects bits 15:8 and pulls the upper-byte select low. A lane whose enable bit is clear keeps its select high for the whole access.
- R5: A read samples the incoming bus at the end of its last wait cycle. `rspValid` is then high for exactly one cycle, the cycle that follows. `rspRData` carries the sampled lanes, and every lane that was not selected reads as zero.
- R6: In the cycle after a write's last wait cycle, chip enable is still low, write enable is high, the bus is released and `busy` is high. The controller is idle in the cycle after that.
- R7: A request with an all-zero byte mask never pulls chip, output or write enable low. `busy` is high for one cycle. A read of this kind gives a `rspValid` pulse with zero data in the following cycle. A write of this kind gives no response.
- R8: A request is accepted at a clock edge where `reqValid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the last wait cycle of a read, or through the release cycle of a write. Requests presented while `busy` is high are ignored and do not affect the pins of the access in progress.
- R9: WAIT_CYC equals ACCESS_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqByteEn | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| reqWData | input | 16 | Write data |
| busy | output | 1 | Access in progress, requests ignored |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspRData | output | 16 | Read data, unselected lanes zero |
| memAddr | output | 17 | Memory address pins |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper-byte select, active low |
| memLbN | output | 1 | Lower-byte select, active low |
| memDqOut | output | 16 | Data toward the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data from the memory |

## Verification
The assertions assume that the memory model answers reads only while chip and output enable are both low and write enable is high. They also assume the requester never sees `busy` from inside the current cycle, so any request it raises during an access arrives only at edges where the controller is busy. The bench models the memory in exactly that way and refreshes its read data between clock edges. It lowers `reqValid` in the first cycle in which it sees `busy` low. A request held during an access is therefore never accepted by accident once the access ends. Random masks include the all-zero case, and some accesses are run with a conflicting request held high the whole time, so that both the empty and the ignored paths are exercised.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // latch a new request
    logic chipSel;   // chip selected (access or release)
    logic readEn;    // output enable asserted
    logic writeEn;   // write enable asserted
    logic driveBus;  // controller drives data pins
    logic capture;   // sample read data, raise response
  } ctlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RELEASE = 2'd2,
    ST_EMPTY   = 2'd3
  } ctlStateT;

  // Wait cycles needed to cover an access time, at least one
  function automatic int waitCycles(input int accessPs, input int clkPs);
    int n;
    n = (accessPs + clkPs - 1) / clkPs;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int WAIT_CYC = 3,
  parameter int CNT_W    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      reqAny,
  output ctlStrobeT strobe,
  output logic      busy
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  ctlStateT         stateQ;
  ctlStateT         stateD;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic             isWriteQ;
  logic             accept;
  logic             lastWait;

  assign accept   = reqValid && (stateQ == ST_IDLE);
  assign lastWait = (stateQ == ST_ACCESS) && (cntQ == '0);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          stateD = reqAny ? ST_ACCESS : ST_EMPTY;
          cntD   = CNT_LOAD;
        end
      end
      ST_ACCESS: begin
        if (cntQ == '0) begin
          stateD = isWriteQ ? ST_RELEASE : ST_IDLE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_RELEASE: stateD = ST_IDLE;
      ST_EMPTY:   stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      isWriteQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      if (accept) begin
        isWriteQ <= reqWrite;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.chipSel  = (stateQ == ST_ACCESS) || (stateQ == ST_RELEASE);
    strobe.readEn   = (stateQ == ST_ACCESS) && !isWriteQ;
    strobe.writeEn  = (stateQ == ST_ACCESS) && isWriteQ;
    strobe.driveBus = (stateQ == ST_ACCESS) && isWriteQ;
    strobe.capture  = !isWriteQ && (lastWait || (stateQ == ST_EMPTY));
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/sram_ctl_dp.sv
`timescale 1ns/1ps
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  laneSelN,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDqOe,
  output logic [DATA_W-1:0] memDqOut,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  laneEnQ;
  logic [DATA_W-1:0] wDataQ;
  logic              rspValidQ;
  logic [LANE_W-1:0] laneDataQ [LANES];

  // Request fields are held for the whole access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      laneEnQ <= '0;
      wDataQ  <= '0;
    end else if (strobe.load) begin
      addrQ   <= reqAddr;
      laneEnQ <= reqByteEn;
      wDataQ  <= reqWData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
    end else begin
      rspValidQ <= strobe.capture;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneSelN[g] = ~(strobe.chipSel & laneEnQ[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneDataQ[g] <= '0;
      end else if (strobe.capture) begin
        laneDataQ[g] <= laneEnQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign rspRData[g*LANE_W +: LANE_W] = laneDataQ[g];
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~strobe.chipSel;
  assign memOeN   = ~strobe.readEn;
  assign memWeN   = ~strobe.writeEn;
  assign memDqOe  = strobe.driveBus;
  assign memDqOut = wDataQ;
  assign rspValid = rspValidQ;

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int ACCESS_PS     = 12000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [DATA_W-1:0] reqWData,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int LANES    = 2;
  localparam int WAIT_CYC = waitCycles(ACCESS_PS, CLK_PERIOD_PS);
  localparam int CNT_W    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  ctlStrobeT        strobe;
  logic [LANES-1:0] laneSelN;
  logic             reqAny;

  assign reqAny = |reqByteEn;

  sram_ctl_fsm #(
    .WAIT_CYC(WAIT_CYC),
    .CNT_W   (CNT_W)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAny  (reqAny),
    .strobe  (strobe),
    .busy    (busy)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqByteEn(reqByteEn),
    .reqWData (reqWData),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .laneSelN (laneSelN),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memDqOe  (memDqOe),
    .memDqOut (memDqOut),
    .rspValid (rspValid),
    .rspRData (rspRData)
  );

  assign memLbN = laneSelN[0];
  assign memUbN = laneSelN[1];

endmodule

// File: rtl/sram_ctl_checker.sv
`timescale 1ns/1ps
module sram_ctl_checker
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int ACCESS_PS     = 12000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic              memDqOe
);

  localparam int WAIT_CYC = waitCycles(ACCESS_PS, CLK_PERIOD_PS);
  localparam int RUN_W    = $clog2(WAIT_CYC + 2) + 1;

  logic             enActive;
  logic [RUN_W-1:0] runLen;

  assign enActive = !memCeN && (!memWeN || !memOeN);

  // Length of the current run of enabled cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (enActive) begin
      runLen <= runLen + 1'b1;
    end else begin
      runLen <= '0;
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memWeN && memOeN && memUbN && memLbN && !memDqOe)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> ($stable(memAddr) && $stable(memUbN) && $stable(memLbN))); // R2

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN)); // R3

  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && !memCeN)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R5

  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!memWeN) && memWeN) |-> (!memCeN && busy && !memDqOe)); // R6

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> memCeN); // R8

  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ((runLen != '0) && !enActive) |-> (runLen == RUN_W'(WAIT_CYC))); // R9

endmodule

bind async_sram_ctrl sram_ctl_checker #(
  .ADDR_W       (ADDR_W),
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .ACCESS_PS    (ACCESS_PS)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memUbN  (memUbN),
  .memLbN  (memLbN),
  .memDqOe (memDqOe)
);

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_async_sram_ctrl;

  localparam int CLK_PS = 5000;
  localparam int ACC_PS = 12000;

  function automatic int expWait();
    int n;
    n = ACC_PS / CLK_PS;
    if (n * CLK_PS < ACC_PS) n++;
    if (n < 1) n = 1;
    return n;
  endfunction

  localparam int W = expWait();  // R9

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [1:0]  reqByteEn = '0;
  logic [15:0] reqWData = '0;
  logic        busy, rspValid, memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe;
  logic [15:0] rspRData, memDqOut;
  logic [15:0] memDqIn = '0;
  logic [16:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] ram [int];
  logic [15:0] shadow [int];
  logic [16:0] pool [16];
  logic [15:0] junk = 16'hC35A;

  always #2.5 clk = ~clk;

  async_sram_ctrl #(
    .CLK_PERIOD_PS(CLK_PS),
    .ACCESS_PS    (ACC_PS)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWData(reqWData),
    .busy(busy), .rspValid(rspValid), .rspRData(rspRData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Memory model: writes and read data updated between clock edges
  always @(negedge clk) begin
    logic [15:0] w;
    junk = {junk[14:0], junk[15] ^ junk[13]};
    if (rstN && !memCeN && !memWeN && memDqOe) begin
      w = ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 16'h0;
      if (!memLbN) w[7:0]  = memDqOut[7:0];
      if (!memUbN) w[15:8] = memDqOut[15:8];
      ram[int'(memAddr)] = w;
    end
    memDqIn = junk;
    if (!memCeN && !memOeN && memWeN) begin
      w = ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 16'h0;
      if (!memLbN) memDqIn[7:0]  = w[7:0];
      if (!memUbN) memDqIn[15:8] = w[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk(memCeN && memOeN && memWeN && memUbN && memLbN && !memDqOe && !busy && !rspValid,
        "R1", tag, {26'd0, memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe},
        32'h3E);
  endtask

  task automatic runOp(input bit wr, input logic [16:0] a, input logic [1:0] be,
                       input logic [15:0] d, input bit noise);
    int act = 0, ceSeen = 0, rspCnt = 0, rspAt = 0, busyLast = 0;
    bit pinBad = 0, relOk = 0;
    logic [15:0] rspD = '0, expD;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqByteEn = be; reqWData = d;
    for (int c = 1; c <= W + 4; c++) begin
      @(negedge clk);
      if (c == 1) begin
        if (noise) begin
          reqWrite = ~wr; reqAddr = a ^ 17'h155A5; reqByteEn = ~be; reqWData = ~d;
        end else begin
          reqValid = 1'b0;
        end
      end
      if (!busy) reqValid = 1'b0;
      if (!memCeN) ceSeen++;
      if (!memCeN && (!memWeN || !memOeN)) begin
        act++;
        if (memAddr != a || memLbN != !be[0] || memUbN != !be[1]) pinBad = 1;
        if (wr && !(!memWeN && memOeN && memDqOe && memDqOut == d)) pinBad = 1;
        if (!wr && !(!memOeN && memWeN && !memDqOe)) pinBad = 1;
      end else if (memDqOe) begin
        pinBad = 1;
      end
      if (rspValid) begin rspCnt++; rspAt = c; rspD = rspRData; end
      if (busy) busyLast = c;
      if (wr && c == W + 1) relOk = memWeN && !memCeN && !memDqOe && busy && (memAddr == a);
    end
    reqValid = 1'b0;
    if (be == 2'b00) begin
      chk(ceSeen == 0, "R7", "chip enable cycles", ceSeen, 0);
      chk(busyLast == 1, "R7", "busy length", busyLast, 1);
      if (wr) chk(rspCnt == 0, "R7", "write response count", rspCnt, 0);
      else chk(rspCnt == 1 && rspAt == 2 && rspD == 16'h0, "R7", "empty read response",
               {rspAt[15:0], rspD}, {16'd2, 16'h0});
    end else begin
      chk(act == W, wr ? "R3" : "R2", "enabled cycles", act, W);
      chk(!pinBad, noise ? "R8" : "R4", "pins during access", pinBad, 0);
      chk(busyLast == (wr ? W + 1 : W), "R8", "busy length", busyLast, wr ? W + 1 : W);
      if (wr) begin
        chk(relOk, "R6", "release cycle", relOk, 1);
        chk(rspCnt == 0, "R3", "write response count", rspCnt, 0);
        expD = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (be[0]) expD[7:0]  = d[7:0];
        if (be[1]) expD[15:8] = d[15:8];
        shadow[int'(a)] = expD;
      end else begin
        expD = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (!be[0]) expD[7:0]  = 8'h0;
        if (!be[1]) expD[15:8] = 8'h0;
        chk(rspCnt == 1 && rspAt == W + 1, "R5", "response timing",
            {rspCnt[15:0], rspAt[15:0]}, {16'd1, 16'(W + 1)});
        chk(rspD == expD, "R5", "read data", rspD, expD);
      end
    end
    chkIdle("idle after op");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) pool[i] = 17'((i * 32'h0A3B5 + 32'h1234) & 32'h1FFFF);
    pool[0] = 17'h00000;
    pool[15] = 17'h1FFFF;
    repeat (3) @(negedge clk);
    chkIdle("during reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("after reset");
    // Directed: fill, read back, single lanes, empty masks, ignored requests
    for (int i = 0; i < 16; i++) runOp(1'b1, pool[i], 2'b11, 16'(32'hA000 + i * 32'h0111), 1'b0);
    for (int i = 0; i < 16; i++) runOp(1'b0, pool[i], 2'b11, 16'h0, 1'b0);
    runOp(1'b1, pool[3], 2'b01, 16'h5AE7, 1'b0);  // R4 lower lane only
    runOp(1'b0, pool[3], 2'b11, 16'h0, 1'b0);
    runOp(1'b1, pool[3], 2'b10, 16'h96C3, 1'b0);  // R4 upper lane only
    runOp(1'b0, pool[3], 2'b01, 16'h0, 1'b0);     // R5 upper lane zero
    runOp(1'b0, pool[3], 2'b10, 16'h0, 1'b0);
    runOp(1'b1, pool[5], 2'b00, 16'hFFFF, 1'b0);  // R7 empty write
    runOp(1'b0, pool[5], 2'b11, 16'h0, 1'b0);
    runOp(1'b0, pool[5], 2'b00, 16'h0, 1'b0);     // R7 empty read
    runOp(1'b1, pool[7], 2'b11, 16'h1357, 1'b1);  // R8 noise during write
    runOp(1'b0, pool[7], 2'b11, 16'h0, 1'b1);     // R8 noise during read
    runOp(1'b0, pool[7 ^ 1], 2'b11, 16'h0, 1'b0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      runOp(1'($urandom_range(0, 1)), pool[$urandom_range(0, 15)],
            2'($urandom_range(0, 3)), 16'($urandom), ($urandom_range(0, 2) == 0));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule